// File: doc/BRIEF.md
# Blocking neighbour link mesh with multiport access

This block joins a grid of small processor cores through rendezvous links. Every pair of cores that sit next to each other shares a single one-word link. There is no queue on a link. A core that issues a write is held until the neighbour on the other side takes the word. A core that issues a read is held until a neighbour offers a word. The waiting core is released in the same cycle the partner completes, so no polling is needed.

Each core talks to the block through a request/stall handshake. The request carries:
- a four-bit one-hot-or-more port mask;
- a direction bit;
- a write word;
- for reads, a flag that marks the access as an instruction fetch.

The fetch flag comes back with the data, so the core can execute the received word instead of storing it. One request may name several ports. It completes through exactly one of them, and offers on the other named ports end at that point.

The grid is ROWS x COLS cores. Core index = row*COLS + col. Port 0 faces north (row-1), port 1 east (col+1), port 2 south (row+1) and port 3 west (col-1). A link joins port p of one core to port p^2 of its neighbour.

Top module: `nbr_link_mesh`

## Requirements
- R1: A read (wr=0) whose mask names no port where the neighbour is offering a word toward it keeps its stall high while req stays high. A read whose mask meets such an offer drops stall in that same cycle.
- R2: A write (wr=1) keeps stall high until a neighbour on one of its named ports is reading toward it. Stall drops in the cycle that read completes, and the reader's stall drops in the same cycle.
- R3: On completion, the word from the writer's wdata appears on the reader's rdata after the next rising clock edge. A core's rdata does not change in any cycle in which it completes no read.
- R4: When a multiport read meets several offering neighbours in one cycle, the lowest-numbered port wins. Only the writer on that port is released, and the other writers stay stalled.
- R5: A multiport write completes with only one reader per cycle: the lowest-numbered named port whose neighbour reads. The other readers stay stalled and their rdata is unchanged.
- R6: The reader's fetch input is registered with the data on rfetch at completion (1 = instruction fetch).
- R7: Two neighbours that both write the same link toward each other both stay stalled until one of them turns to a read.
- R8: While rst is high every stall is low. After a rising edge with rst high, every rdata and rfetch is zero.
- R9: A port that faces off the edge of the grid never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | ROWS*COLS | Access request, one bit per core |
| wr | input | ROWS*COLS | Direction per core, 1 = write, 0 = read |
| fetch | input | ROWS*COLS | Read is an instruction fetch |
| mask | input | 4*ROWS*COLS | Port select per core, bits [4i+3:4i] for core i |
| wdata | input | W*ROWS*COLS | Write word per core |
| stall | output | ROWS*COLS | Core must hold its request |
| rdata | output | W*ROWS*COLS | Last word received per core |
| rfetch | output | ROWS*COLS | Fetch flag of the last completed read |

## Verification
Stall is combinational from the requests, so each stall result is due in the cycle the requests are applied. The bench drives at the falling edge and reads stall one nanosecond later. rdata and rfetch pass through one register, so they are read one nanosecond after the next rising edge, and the unchanged value of cores that lost arbitration is checked there too. The centre core of a 3x3 grid is swept over every port mask against every subset of offering or reading neighbours. The winner is computed in the bench as the lowest set bit of the overlap.

// File: rtl/nbr_link_mesh.sv
module nbr_link_mesh #(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int W = 18,
  localparam int N = ROWS * COLS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req,
  input  logic [N-1:0]   wr,
  input  logic [N-1:0]   fetch,
  input  logic [4*N-1:0] mask,
  input  logic [W*N-1:0] wdata,
  output logic [N-1:0]   stall,
  output logic [W*N-1:0] rdata,
  output logic [N-1:0]   rfetch
);

  function automatic logic nb_ok(int i, int p);
    int r, c;
    r = i / COLS;
    c = i % COLS;
    case (p)
      0: return r > 0;
      1: return c < COLS - 1;
      2: return r < ROWS - 1;
      default: return c > 0;
    endcase
  endfunction

  function automatic int nb_id(int i, int p);
    if (!nb_ok(i, p)) return i;
    case (p)
      0: return i - COLS;
      1: return i + 1;
      2: return i + COLS;
      default: return i - 1;
    endcase
  endfunction

  logic [N-1:0][3:0] offer, want, cand, rsel, wcand, wsel, acc;
  logic [N-1:0][W-1:0] rword;
  logic [N-1:0] rd_done, wr_done;

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int p = 0; p < 4; p++) begin
        offer[i][p] = req[i] & wr[i] & mask[4*i+p] & nb_ok(i, p);
        want[i][p]  = req[i] & ~wr[i] & mask[4*i+p] & nb_ok(i, p);
      end
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 4; p++)
        cand[i][p] = want[i][p] & offer[nb_id(i, p)][p ^ 2];
      rsel[i] = cand[i] & (~cand[i] + 4'd1);
    end
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 4; p++)
        wcand[i][p] = offer[i][p] & rsel[nb_id(i, p)][p ^ 2];
      wsel[i] = wcand[i] & (~wcand[i] + 4'd1);
    end
    for (int i = 0; i < N; i++) begin
      rword[i] = '0;
      for (int p = 0; p < 4; p++) begin
        acc[i][p] = rsel[i][p] & wsel[nb_id(i, p)][p ^ 2];
        if (acc[i][p]) rword[i] = wdata[nb_id(i, p)*W +: W];
      end
      rd_done[i] = |acc[i];
      wr_done[i] = |wsel[i];
    end
  end

  assign stall = req & ~(rd_done | wr_done) & {N{~rst}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rfetch <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (rd_done[i]) begin
          rdata[i*W +: W] <= rword[i];
          rfetch[i]       <= fetch[i];
        end
    end
  end

  p_balance_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_done) == $countones(wr_done));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (rdata == '0 && rfetch == '0));

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !rd_done[g] |=> $stable(rdata[g*W +: W]));
    for (genvar q = 0; q < 4; q++) begin : g_port
      p_write_pairs_r2: assert property (@(posedge clk) disable iff (rst)
        wsel[g][q] |-> rd_done[nb_id(g, q)]);
      p_link_dead_r7: assert property (@(posedge clk) disable iff (rst)
        (offer[g][q] && offer[nb_id(g, q)][q ^ 2]) |-> !wsel[g][q]);
    end
  end

endmodule

// File: tb/sim_nbr_link_mesh.sv
module sim_nbr_link_mesh;
  localparam int N = 9;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, wr = '0, fetch = '0;
  logic [4*N-1:0] mask = '0;
  logic [W*N-1:0] wdata = '0;
  logic [N-1:0] stall, rfetch;
  logic [W*N-1:0] rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] exp_rd [N];
  logic exp_f [N];
  int nbr [4] = '{1, 5, 7, 3};

  always #2.5 clk = ~clk;

  nbr_link_mesh #(.ROWS(3), .COLS(3), .W(W)) u0 (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .fetch(fetch), .mask(mask),
    .wdata(wdata), .stall(stall), .rdata(rdata), .rfetch(rfetch));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    req = '0; wr = '0; fetch = '0; mask = '0;
  endtask

  task automatic drive(input int c, input bit w, input logic [3:0] m, input logic [W-1:0] d, input bit f);
    req[c] = 1'b1; wr[c] = w; mask[4*c +: 4] = m; wdata[c*W +: W] = d; fetch[c] = f;
  endtask

  function automatic logic [W-1:0] word(int m, int s, int p);
    return W'((m * 16 + s) * 5 + p * 3 + 1);
  endfunction

  function automatic int lowest(logic [3:0] v);
    for (int p = 0; p < 4; p++) if (v[p]) return p;
    return -1;
  endfunction

  task automatic check_rdata(input string tag);
    for (int c = 0; c < N; c++) begin
      chk(rdata[c*W +: W] == exp_rd[c], tag, 32'(rdata[c*W +: W]), 32'(exp_rd[c]));
      chk(rfetch[c] == exp_f[c], {tag, " R6 fetch flag"}, 32'(rfetch[c]), 32'(exp_f[c]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin exp_rd[c] = '0; exp_f[c] = 1'b0; end
    // R8: requests present during reset
    @(negedge clk);
    for (int c = 0; c < N; c++) drive(c, c[0], 4'hF, W'(c + 1), 1'b1);
    #1 chk(stall == '0, "R8 stall in reset", 32'(stall), 0);
    @(posedge clk); #1;
    check_rdata("R8 rdata after reset");
    @(negedge clk); clear_all(); rst = 1'b0;

    // R1 R3 R4 R6: centre reads, neighbour subsets offer
    for (int m = 1; m < 16; m++)
      for (int s = 0; s < 16; s++) begin
        logic [3:0] hit;
        int a;
        @(negedge clk); clear_all();
        drive(4, 1'b0, 4'(m), '0, s[0]);
        for (int p = 0; p < 4; p++)
          if (s[p]) drive(nbr[p], 1'b1, 4'(1 << (p ^ 2)), word(m, s, p), 1'b0);
        hit = 4'(m) & 4'(s);
        a = lowest(hit);
        #1;
        chk(stall[4] == (hit == 0), "R1 reader stall", 32'(stall[4]), 32'(hit == 0));
        for (int p = 0; p < 4; p++)
          if (s[p]) chk(stall[nbr[p]] == !(p == a), "R4 writer stall", 32'(stall[nbr[p]]), 32'(!(p == a)));
        @(posedge clk); #1;
        if (a >= 0) begin exp_rd[4] = word(m, s, a); exp_f[4] = s[0]; end
        check_rdata("R3 read data");
      end

    // R2 R5: centre writes, neighbour subsets read
    for (int m = 1; m < 16; m++)
      for (int s = 0; s < 16; s++) begin
        logic [3:0] hit;
        int a;
        @(negedge clk); clear_all();
        drive(4, 1'b1, 4'(m), word(m, s, 7), 1'b0);
        for (int p = 0; p < 4; p++)
          if (s[p]) drive(nbr[p], 1'b0, 4'(1 << (p ^ 2)), '0, p[0]);
        hit = 4'(m) & 4'(s);
        a = lowest(hit);
        #1;
        chk(stall[4] == (hit == 0), "R2 writer stall", 32'(stall[4]), 32'(hit == 0));
        for (int p = 0; p < 4; p++)
          if (s[p]) chk(stall[nbr[p]] == !(p == a), "R5 reader stall", 32'(stall[nbr[p]]), 32'(!(p == a)));
        @(posedge clk); #1;
        if (a >= 0) begin exp_rd[nbr[a]] = word(m, s, 7); exp_f[nbr[a]] = a[0]; end
        check_rdata("R5 other readers unchanged");
      end

    // R7: both ends write one link
    @(negedge clk); clear_all();
    drive(4, 1'b1, 4'b0010, 18'h2AAAA, 1'b0);
    drive(5, 1'b1, 4'b1000, 18'h15555, 1'b0);
    repeat (3) begin
      @(posedge clk); #1;
      chk(stall[4] && stall[5], "R7 write-write hold", 32'({stall[4], stall[5]}), 3);
    end
    @(negedge clk); drive(5, 1'b0, 4'b1000, '0, 1'b1);
    #1 chk(!stall[4] && !stall[5], "R7 released by read", 32'({stall[4], stall[5]}), 0);
    @(posedge clk); #1;
    exp_rd[5] = 18'h2AAAA; exp_f[5] = 1'b1;
    check_rdata("R7 data after release");

    // R9: off-grid ports
    @(negedge clk); clear_all();
    drive(0, 1'b0, 4'b1001, '0, 1'b0);
    drive(8, 1'b1, 4'b0110, 18'h00123, 1'b0);
    drive(3, 1'b1, 4'b1000, 18'h00456, 1'b0);
    repeat (2) begin
      @(posedge clk); #1;
      chk(stall[0] && stall[8] && stall[3], "R9 edge ports", 32'({stall[0], stall[8], stall[3]}), 7);
    end
    @(posedge clk); #1;
    check_rdata("R9 no data from edge");

    // R8: reset mid-run clears data
    @(negedge clk); clear_all(); rst = 1'b1;
    @(posedge clk); #1;
    for (int c = 0; c < N; c++) begin exp_rd[c] = '0; exp_f[c] = 1'b0; end
    check_rdata("R8 reset clears");
    @(negedge clk); rst = 1'b0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule